// File: doc/BRIEF.md
# Register Write-Protection Key Unlocker

This block protects a bank of configuration registers from stray writes. It sits on a simple memory-mapped bus that has an address, write data, a write strobe, a read strobe and read data. It decodes one key register at byte address 0x0. Every other address belongs to the guarded bank. The block drives `write_allowed`, which qualifies the current bus write for the bank. That qualifier is high only while the block is unlocked and the write targets a guarded address.

Software unlocks the bank with four consecutive key writes: 0x00A5, then 0x0001, then 0xFFFE, then 0x0001. Writing 0x0000 to the key register restores protection. Software has two ways to use it:
- Wrap every guarded write in a full unlock and relock, for any number of cycles.
- Unlock once at start-up and leave the bank open.

A state machine checks the sequence with these states: `ST_LOCKED` (idle), `ST_KEY1`, `ST_KEY2`, `ST_KEY3` (one, two or three words accepted) and `ST_OPEN`. The transitions are:
- **advance**: the correct next key word moves the machine one step forward. `ST_KEY3` followed by 0x0001 moves to `ST_OPEN`.
- **restart**: a wrong key word of 0x00A5 moves to `ST_KEY1`.
- **mismatch**: any other wrong key word moves to `ST_LOCKED`.
- **abort**: a guarded write in the middle of the sequence moves to `ST_LOCKED`.
- **relock**: a key write of zero from `ST_OPEN` moves to `ST_LOCKED`.
- **hold**: every other bus cycle, including any read, keeps the state.

Top module: `ukey_guard`

## Requirements
- R1: After reset the block is locked with the checker idle. A status read returns 0 and guarded writes see `write_allowed` low.
- R2: Four consecutive key writes (address 0x0) of the full data words 0x00000A5, 0x00000001, 0x0000FFFE and 0x00000001, in that order, unlock the block from the next clock edge onward. A word whose upper bits are nonzero never matches.
- R3: While locked, including partway through the sequence, `write_allowed` stays low for every guarded write.
- R4: While unlocked, `write_allowed` is high in the same cycle as a write to any address other than 0x0. It is low when no write is strobed and for writes to the key address.
- R5: A key write of 0x00000000 while unlocked returns the block to the locked, idle state.
- R6: A wrong key word during the sequence resets the checker to idle. If that word is 0x000000A5, it counts instead as the first word of a new attempt.
- R7: A guarded write while one to three key words have been accepted aborts the sequence and is itself blocked.
- R8: A read strobed at address 0x0 returns bit 0 = 1 when unlocked and 0 otherwise, with all other bits 0. Reads of any other address return 0.
- R9: While unlocked, key writes of nonzero values leave the block unlocked.
- R10: Unlock and relock can be repeated any number of times, and each full sequence unlocks again.
- R11: Reads, and idle bus cycles, never advance or abort the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data (status at the key address) |
| write_allowed | output | 1 | Qualifies the current write for the guarded bank |

## Verification
The hardest situations to reach are interruptions of a partly entered sequence, because the step the checker has reached is never visible at the ports. The bench interrupts the sequence after every prefix length from zero to three words. The interruptions are a wrong word, the restart word 0x00A5, a guarded write, a key read and a zero write. The bench then sends the rest of the sequence and observes whether the status bit reads 1. From that it infers whether the checker went back to idle, kept its step or restarted.

// File: rtl/ukey_pkg.sv
package ukey_pkg;

    typedef enum logic [2:0] {
        ST_LOCKED = 3'd0,
        ST_KEY1   = 3'd1,
        ST_KEY2   = 3'd2,
        ST_KEY3   = 3'd3,
        ST_OPEN   = 3'd4
    } step_e;

    localparam logic [15:0] KEY_FIRST  = 16'h00A5;
    localparam logic [15:0] KEY_MIDDLE = 16'h0001;
    localparam logic [15:0] KEY_THIRD  = 16'hFFFE;
    localparam logic [15:0] KEY_CLOSE  = 16'h0000;

endpackage

// File: rtl/ukey_word_match.sv
module ukey_word_match
    import ukey_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] wdata,
    output logic              m_first,
    output logic              m_mid,
    output logic              m_third,
    output logic              m_zero
);
    localparam logic [DATA_W-1:0] W_FIRST = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] W_MID   = DATA_W'(KEY_MIDDLE);
    localparam logic [DATA_W-1:0] W_THIRD = DATA_W'(KEY_THIRD);
    localparam logic [DATA_W-1:0] W_ZERO  = DATA_W'(KEY_CLOSE);

    always_comb begin
        m_first = (wdata == W_FIRST);
        m_mid   = (wdata == W_MID);
        m_third = (wdata == W_THIRD);
        m_zero  = (wdata == W_ZERO);
    end
endmodule

// File: rtl/ukey_seq_fsm.sv
module ukey_seq_fsm
    import ukey_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic other_wr,
    input  logic m_first,
    input  logic m_mid,
    input  logic m_third,
    input  logic m_zero,
    output logic unlocked
);
    step_e state, state_nx;

    // Next-state selection for each step of the sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (key_wr && m_first) state_nx = ST_KEY1;
            end
            ST_KEY1: begin
                if (other_wr)                 state_nx = ST_LOCKED;
                else if (key_wr && m_mid)     state_nx = ST_KEY2;
                else if (key_wr && m_first)   state_nx = ST_KEY1;
                else if (key_wr)              state_nx = ST_LOCKED;
            end
            ST_KEY2: begin
                if (other_wr)                 state_nx = ST_LOCKED;
                else if (key_wr && m_third)   state_nx = ST_KEY3;
                else if (key_wr && m_first)   state_nx = ST_KEY1;
                else if (key_wr)              state_nx = ST_LOCKED;
            end
            ST_KEY3: begin
                if (other_wr)                 state_nx = ST_LOCKED;
                else if (key_wr && m_mid)     state_nx = ST_OPEN;
                else if (key_wr && m_first)   state_nx = ST_KEY1;
                else if (key_wr)              state_nx = ST_LOCKED;
            end
            ST_OPEN: begin
                if (key_wr && m_zero) state_nx = ST_LOCKED;
            end
            default: state_nx = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        unlocked = (state == ST_OPEN);
    end

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY3 && key_wr && m_mid && !other_wr) |=> (state == ST_OPEN));

    assert_open_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(state) == ST_KEY3));

    assert_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && m_zero) |=> (state == ST_LOCKED));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state inside {ST_KEY1, ST_KEY2, ST_KEY3}) && key_wr && m_first && !other_wr)
        |=> (state == ST_KEY1));

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state inside {ST_KEY1, ST_KEY2, ST_KEY3}) && other_wr) |=> (state == ST_LOCKED));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr && !other_wr) |=> $stable(state));
endmodule

// File: rtl/ukey_guard.sv
module ukey_guard
    import ukey_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              write_allowed
);
    logic key_hit, key_wr, other_wr;
    logic m_first, m_mid, m_third, m_zero;
    logic unlocked;

    always_comb begin
        key_hit  = (bus_addr == KEY_ADDR);
        key_wr   = bus_we && key_hit;
        other_wr = bus_we && !key_hit;
    end

    ukey_word_match #(.DATA_W(DATA_W)) u_match (
        .wdata   (bus_wdata),
        .m_first (m_first),
        .m_mid   (m_mid),
        .m_third (m_third),
        .m_zero  (m_zero)
    );

    ukey_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .other_wr (other_wr),
        .m_first  (m_first),
        .m_mid    (m_mid),
        .m_third  (m_third),
        .m_zero   (m_zero),
        .unlocked (unlocked)
    );

    always_comb begin
        write_allowed = other_wr && unlocked;
        bus_rdata     = (bus_re && key_hit) ? DATA_W'(unlocked) : '0;
    end

    assert_key_never_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && key_hit) |-> !write_allowed);
endmodule

// File: tb/ukey_guard_test.sv
`timescale 1ns/1ps
module ukey_guard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata;
    logic        write_allowed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ukey_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .write_allowed(write_allowed)
    );

    function automatic logic [31:0] seq_word(input int i);
        case (i)
            0: return 32'h0000_00A5;
            1: return 32'h0000_0001;
            2: return 32'h0000_FFFE;
            default: return 32'h0000_0001;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d,
                      input bit exp_ok, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #1;
        checks++;
        if (write_allowed !== exp_ok) begin
            errors++;
            $display("FAIL %s: write_allowed addr=%h data=%h act=%0b exp=%0b",
                     req, a, d, write_allowed, exp_ok);
        end
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata addr=%h act=%h exp=%h", req, a, bus_rdata, exp);
        end
        @(posedge clk);
        #1 bus_re = 1'b0;
    endtask

    task automatic send_from(input int k);
        for (int i = k; i < 4; i++) wr(8'h00, seq_word(i), 1'b0, "R2");
    endtask

    task automatic relock();
        wr(8'h00, 32'h0, 1'b0, "R5");
        rd(8'h00, 32'h0, "R5");
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, 32'h0, "R1");
        wr(8'h04, 32'hDEAD_BEEF, 1'b0, "R1");

        // R4: no strobe, no qualifier
        @(negedge clk); bus_addr = 8'h04; #1; checks++;
        if (write_allowed !== 1'b0) begin
            errors++; $display("FAIL R4: idle write_allowed act=%0b exp=0", write_allowed);
        end

        // R2 basic unlock, R4/R8/R9 while open
        send_from(0);
        rd(8'h00, 32'h1, "R2");
        wr(8'h04, 32'h1234, 1'b1, "R4");
        wr(8'hFC, 32'h5678, 1'b1, "R4");
        rd(8'h04, 32'h0, "R8");
        wr(8'h00, 32'h5555, 1'b0, "R9");
        wr(8'h00, 32'h00A5, 1'b0, "R9");
        rd(8'h00, 32'h1, "R9");
        relock();
        wr(8'h04, 32'h1, 1'b0, "R3");

        // R2: upper bits nonzero never match
        wr(8'h00, 32'h0001_00A5, 1'b0, "R2");
        send_from(1);
        rd(8'h00, 32'h0, "R2");

        // Interruption sweep: prefix length k, kind of interruption
        for (int k = 0; k < 4; k++) begin
            for (int kind = 0; kind < 5; kind++) begin
                bit exp_open;
                relock();
                for (int i = 0; i < k; i++) wr(8'h00, seq_word(i), 1'b0, "R2");
                case (kind)
                    0: begin wr(8'h00, seq_word(k) ^ 32'h100, 1'b0, "R6"); exp_open = (k == 0); end
                    1: begin wr(8'h00, 32'h00A5, 1'b0, "R6"); exp_open = 1'b1; end
                    2: begin wr(8'h08, 32'hAAAA, 1'b0, "R7"); exp_open = (k == 0); end
                    3: begin rd(8'h00, 32'h0, "R11"); exp_open = 1'b1; end
                    default: begin wr(8'h00, 32'h0, 1'b0, "R6"); exp_open = (k == 0); end
                endcase
                rd(8'h00, 32'h0, "R3");
                if (kind == 1) send_from(1);
                else           send_from(k);
                rd(8'h00, {31'b0, exp_open}, (kind == 2) ? "R7" :
                                             (kind == 3) ? "R11" : "R6");
                wr(8'h10, 32'h3, exp_open, "R4");
            end
        end

        // R10: repeated unlock / write / relock cycles
        for (int n = 0; n < 20; n++) begin
            send_from(0);
            wr(8'h04, n, 1'b1, "R10");
            relock();
            wr(8'h04, n, 1'b0, "R10");
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule